// File: doc/BRIEF.md
# Four-Line Legacy Interrupt Status and Mask Register

This block collects four level-sensitive legacy interrupt lines (A, B, C, D) into one 32-bit control word. It records a pending flag for each line and keeps a per-line enable. It drives a single registered interrupt request to a parent interrupt controller. The same word also stores a set of error-report mask bits, seven request-priority flags and a four-bit ready-wait count. This block keeps those fields only as storage. Other logic decodes them.

Software accesses the word as one register: a write strobe, four byte-lane strobes and a 32-bit write word, with the current contents always visible on the read bus. Pending flags are write-one-to-clear. A driver can therefore do a read-modify-write with zeroes in the pending field and leave outstanding interrupts untouched. A single half-word write of 0xF000 to the upper half clears every pending flag and disables every line in one access.

Each line has a small state machine with two states. LN_IDLE moves to LN_PEND when the line is seen high. LN_PEND moves back to LN_IDLE when the line is acknowledged while it is low, and stays in LN_PEND otherwise. The output stage has two states. IRQ_QUIET moves to IRQ_RAISED when any enabled line is pending. IRQ_RAISED moves back to IRQ_QUIET when none is.

Top module: `intx_ctrl_reg`

## Requirements
- R1: After reset every field reads zero, `reg_rdata` is 0x00000000 and `irq_out` is low.
- R2: If line n (`irq_lvl[n]`, active high) is high at a clock edge, status bit 28+n reads 1 after that edge, whatever its enable is.
- R3: A write with byte strobe 3 set and a 1 in bit 28+n clears status bit n, provided line n is low at that edge. A 0 in bit 28+n leaves the status bit unchanged.
- R4: If a status bit is acknowledged while its line is still high, it remains set.
- R5: Enable bit 22+n unmasks line n. `irq_out` goes high one edge after some status bit and its enable are both 1. It goes low one edge after no such pair exists. `irq_out` has no combinational path from `irq_lvl`.
- R6: The error masks in bits 27:26 and 21:16 are plain read/write storage.
- R7: The request-priority flags in bits 14:8 and the ready-wait count in bits 3:0 are plain read/write storage.
- R8: The reserved bits 15 and 7:4 always read 0, and writes to them are ignored.
- R9: A write changes only the byte lanes whose strobe is set (lane k covers bits 8k+7:8k).
- R10: Writing 0xF000 to the upper half-word (strobes 4'b1100) clears all four status bits and all four enables, and leaves bits 15:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 4 | Level interrupt lines, bit 0 = A to bit 3 = D, active high |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_be | input | 4 | Byte-lane strobes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current contents of the control word |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The assertions assume that `irq_lvl` is synchronous to `clk` and stable around each edge. They also assume that `reg_wr` is a single-cycle strobe with its data and byte strobes valid in the same cycle. The stimulus meets these conditions by changing every input only on the falling edge and by dropping `reg_wr` after each edge. The main sweep covers all sixteen line patterns against all sixteen enable patterns, so the level, acknowledge and masking behaviour is exercised across the whole small space.

// File: rtl/intx_pkg.sv
package intx_pkg;

    localparam int LINES    = 4;
    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
    localparam int STS_LSB  = 28;
    localparam int EN_LSB   = 22;
    localparam int ACK_LANE = STS_LSB / 8;
    localparam logic [WORD_W-1:0] STORE_MASK = 32'h0FFF_7F0F;

    typedef enum logic { LN_IDLE, LN_PEND } line_state_t;
    typedef enum logic { IRQ_QUIET, IRQ_RAISED } irq_state_t;

    function automatic logic [7:0] lane_mask(input int lane);
        return STORE_MASK[8*lane +: 8];
    endfunction

endpackage

// File: rtl/intx_line_ctl.sv
module intx_line_ctl
    import intx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic ack_i,
    output logic pend_o
);

    line_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (lvl_i)           state_d = LN_PEND;
            LN_PEND: if (ack_i && !lvl_i) state_d = LN_IDLE;
            default:                      state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == LN_PEND);
    end

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_i |=> pend_o);                                    // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !lvl_i) |=> !pend_o);                       // R3
    AST_NO_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !lvl_i) |=> $stable(pend_o));              // R3

endmodule

// File: rtl/intx_byte_store.sv
module intx_byte_store #(
    parameter logic [7:0] KEEP = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] d_i,
    output logic [7:0] q_o
);

    logic [7:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (we_i) q <= d_i & KEEP;
    end

    assign q_o = q;

    AST_LANE_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o));                              // R9
    AST_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (q_o == ($past(d_i) & KEEP)));               // R6

endmodule

// File: rtl/intx_ctrl_reg.sv
module intx_ctrl_reg
    import intx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  irq_lvl,
    input  logic        reg_wr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_out
);

    logic [LINES-1:0]  pend;
    logic [LINES-1:0]  ack;
    logic [LINES-1:0]  line_en;
    logic [WORD_W-1:0] store_q;
    logic              any_live;
    irq_state_t        irq_q, irq_d;

    // per-line pending state machines
    for (genvar n = 0; n < LINES; n++) begin : g_line
        assign ack[n] = reg_wr && reg_be[ACK_LANE] && reg_wdata[STS_LSB+n];
        intx_line_ctl u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (irq_lvl[n]),
            .ack_i  (ack[n]),
            .pend_o (pend[n])
        );
    end

    // byte-lane storage for enables, masks, priority flags, wait count
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        intx_byte_store #(.KEEP(lane_mask(k))) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we_i  (reg_wr && reg_be[k]),
            .d_i   (reg_wdata[8*k +: 8]),
            .q_o   (store_q[8*k +: 8])
        );
    end

    assign line_en   = store_q[EN_LSB +: LINES];
    assign any_live  = |(pend & line_en);
    assign reg_rdata = {pend, store_q[STS_LSB-1:0]};

    // combined request state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= IRQ_QUIET;
        else        irq_q <= irq_d;
    end

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_QUIET:  if (any_live)  irq_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_live) irq_d = IRQ_QUIET;
            default:                   irq_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_out = (irq_q == IRQ_RAISED);
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        any_live |=> irq_out);                                // R5
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live |=> !irq_out);                              // R5
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[15] == 1'b0 && reg_rdata[7:4] == 4'h0)); // R8
    AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be == 4'b1100 && reg_wdata[31:16] == 16'hF000 && irq_lvl == 4'h0)
        |=> (reg_rdata[31:28] == 4'h0 && reg_rdata[25:22] == 4'h0)); // R10

endmodule

// File: tb/intx_ctrl_reg_test.sv
module intx_ctrl_reg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0]  sts_m = '0;
    logic [31:0] store_m = '0;
    logic        irq_m = 1'b0;
    localparam logic [31:0] WMASK = 32'h0FFF_7F0F;

    always #5 clk = ~clk;

    intx_ctrl_reg uut (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .reg_wr(reg_wr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    task automatic tick(input logic wr, input logic [3:0] be, input logic [31:0] d);
        logic [3:0] ack;
        reg_wr = wr; reg_be = be; reg_wdata = d;
        @(posedge clk);
        irq_m = |(sts_m & store_m[25:22]);
        ack = (wr && be[3]) ? d[31:28] : 4'h0;
        sts_m = (sts_m & ~ack) | irq_lvl;
        if (wr)
            for (int k = 0; k < 4; k++)
                if (be[k]) store_m[8*k +: 8] = d[8*k +: 8] & WMASK[8*k +: 8];
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
    endtask

    task automatic check(input string tag);
        logic [31:0] exp_rd;
        exp_rd = {sts_m, store_m[27:0]};
        checks++;
        if (reg_rdata !== exp_rd || irq_out !== irq_m) begin
            errors++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, reg_rdata, irq_out, exp_rd, irq_m);
        end
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // R6 R8: full write, reserved bits stay zero
        tick(1, 4'b1111, 32'hFFFF_FFFF); check("R6 R8 full write");
        tick(1, 4'b1111, 32'h0000_0000); check("R6 clear all");
        tick(1, 4'b1111, 32'h0C15_0000); check("R6 error masks");
        // R7 storage
        tick(1, 4'b0011, 32'h0000_5A03); check("R7 priority and wait");
        tick(1, 4'b0011, 32'h0000_25FC); check("R7 R8 second pattern");
        // R9: single lane strobe
        tick(1, 4'b0100, 32'hFFFF_FFFF); check("R9 lane 2 only");
        tick(1, 4'b0001, 32'hFFFF_FF00); check("R9 lane 0 only");
        tick(1, 4'b1111, 32'h0000_0000); check("R9 reset fields");

        // R2: pending without enable, irq stays low
        irq_lvl = 4'b0101;
        tick(0, 4'h0, 32'h0); check("R2 latch with no enable");
        irq_lvl = 4'b0000;
        tick(0, 4'h0, 32'h0); check("R2 held after line drops");
        // R3: zero bits keep status, one bits clear
        tick(1, 4'b1000, 32'h2000_0000); check("R3 zero ack keeps");
        tick(1, 4'b1000, 32'h1000_0000); check("R3 ack clears A");
        // R4: ack while still high
        irq_lvl = 4'b1000;
        tick(0, 4'h0, 32'h0); check("R4 set D");
        tick(1, 4'b1000, 32'hF000_0000); check("R4 ack while high stays");
        // ack without lane 3 strobe does nothing (R9)
        irq_lvl = 4'b0000;
        tick(1, 4'b0111, 32'hF000_0000); check("R9 ack needs lane 3");

        // R10: half-word clear
        irq_lvl = 4'b1111;
        tick(1, 4'b1111, 32'h03C0_7A0B); check("R10 setup");
        irq_lvl = 4'b0000;
        tick(0, 4'h0, 32'h0); check("R10 setup irq");
        tick(1, 4'b1100, 32'hF000_0000); check("R10 half clear");
        tick(0, 4'h0, 32'h0); check("R10 irq drops");

        // R5 sweep: every enable pattern against every line pattern
        for (int en = 0; en < 16; en++) begin
            for (int ln = 0; ln < 16; ln++) begin
                irq_lvl = ln[3:0];
                tick(1, 4'b1100, {4'hF, 2'b00, en[3:0], 22'h0});
                check("R4 R5 sweep write");
                irq_lvl = 4'h0;
                tick(0, 4'h0, 32'h0); check("R2 R5 sweep pend");
                tick(0, 4'h0, 32'h0); check("R5 sweep irq");
                tick(1, 4'b1000, 32'hF000_0000); check("R3 sweep ack");
                tick(0, 4'h0, 32'h0); check("R5 sweep irq low");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule